// File: doc/BRIEF.md
# Linked Command-List Sequencer

This block is the front end of a 2D blit engine. Software leaves one or more command lists in memory and points the sequencer at the first one. Each list is a header word holding a pair count, then that many (offset, value) pairs, then one link word. The sequencer fetches the words one at a time over a valid/ready read port and turns each pair into an internal register write. It then follows the link to the next list. A link of zero ends the chain.

A host port, made of plain write strobes and a combinational read, holds the chain base address, the command register, the status word, the hold control, and the interrupt enable and pending registers. When list hold is armed, the sequencer stops at the end of a list, raises an interrupt and waits for the host to issue a continue. The blit datapath is a fixed-latency stub: a list write to the blit-start offset begins one blit, and its completion bumps a counter.

On the memory port a request is offered with `mem_req_valid` and `mem_req_addr`. Both stay stable until `mem_req_ready` is seen high at a clock edge. Only one request is outstanding at a time. The response is taken when `mem_rsp_valid` and `mem_rsp_ready` are high together. `mem_rsp_ready` is high only while a response is awaited, and a response offered at any other time is dropped.

Top module: `cmdlist_sequencer`

## Requirements
- R1: Each list is walked in this order: the header word (pair count N in its low 16 bits), N pairs of offset word then value word, then the link word. Every pair becomes one register write, using bits 11:0 of the offset word. Pairs aimed at the configuration window (offset 0x104 + 4*i, i below the window size) can be read back at the same host offset.
- R2: Memory words are requested at consecutive addresses in steps of 4, starting at the list base. After a nonzero link, requests continue at the link address. The request address is held while valid is high and ready is low.
- R3: A link of zero ends the chain. It sets the done bit (status bit 0) and pending bit 3. The status field in bits 24:17 counts the lists completed since the last start.
- R4: If hold control (host offset 0x090) has bit 1 set when a list ends with a nonzero link, pending bit 1 is set and no memory request is made. A continue (command register 0x084, bit 1) then resumes fetching at the link.
- R5: When the chain ends on a list whose hold bit is set, only the chain-end path is taken: pending bit 1 stays clear and no continue is needed.
- R6: A continue has no effect unless the sequencer is paused at a hold.
- R7: Command bit 0 starts fetching at the base address (host offset 0x080). Command bit 2 halts and returns to idle. Either command clears the done bit, the list count and the blit count.
- R8: A list write of bit 0 to offset 0x100 starts one blit when the stub is idle. Completion after BLIT_LAT cycles increments the status field in bits 16:1 and sets pending bit 0.
- R9: Pending bit 2 is set at the end of every list.
- R10: Pending bits (host offset 0x00C) are cleared by writing 1 to them. `irq` is high when any pending bit has its matching enable bit set (host offset 0x004, bits 3:0).
- R11: A list write with bit 1 set to offset 0x000 clears every configuration-window register.
- R12: Writing zero to hold control, from the host or from a list, disarms the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 12 | Host register offset (write and read) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| irq | output | 1 | Interrupt, any enabled pending bit |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Byte address of requested word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Sequencer awaits read data |
| mem_rsp_data | input | 32 | Read data word |

## Verification
The bench builds linked chains with memory stalls and compares every fetched address against a scoreboard queue. A design that skipped the link word or mis-stepped an address would show a mismatch or a leftover entry. It pauses a chain at a hold, checks that the bus stays quiet and the counters read mid-chain values, and then resumes it. A design that followed the link too early would fetch words the scoreboard never expected. It also checks that a chain ending on a hold-armed list never raises the hold bit, that a stray continue while idle or after a halt fetches nothing, and that a list-issued soft reset wipes the configuration window. The same holds for a start or halt clearing stale counters, a slip that would leave the previous run's counts in the status word.

// File: rtl/cls_pkg.sv
package cls_pkg;
  localparam int HOST_AW = 12;
  localparam int WORD_W  = 32;

  localparam logic [HOST_AW-1:0] OFF_SRESET = 12'h000;
  localparam logic [HOST_AW-1:0] OFF_IEN    = 12'h004;
  localparam logic [HOST_AW-1:0] OFF_IPEND  = 12'h00C;
  localparam logic [HOST_AW-1:0] OFF_BASE   = 12'h080;
  localparam logic [HOST_AW-1:0] OFF_CMD    = 12'h084;
  localparam logic [HOST_AW-1:0] OFF_STAT   = 12'h08C;
  localparam logic [HOST_AW-1:0] OFF_HOLD   = 12'h090;
  localparam logic [HOST_AW-1:0] OFF_BLIT   = 12'h100;
  localparam logic [HOST_AW-1:0] OFF_CFG0   = 12'h104;

  localparam int PEND_BLIT  = 0;
  localparam int PEND_HOLD  = 1;
  localparam int PEND_LEND  = 2;
  localparam int PEND_CHAIN = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP, ST_HOLD} seq_state_e;
  typedef enum logic [1:0] {PH_HDR, PH_OFF, PH_VAL, PH_LNK} seq_phase_e;

  typedef struct packed {
    logic               valid;
    logic [HOST_AW-1:0] off;
    logic [WORD_W-1:0]  data;
  } reg_wr_t;
endpackage

// File: rtl/cls_fetch.sv
module cls_fetch
  import cls_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_cont,
  input  logic              cmd_halt,
  input  logic [WORD_W-1:0] base_addr,
  input  logic              hold_list,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [WORD_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output reg_wr_t           wr_o,
  output logic              ev_list_end,
  output logic              ev_chain_end,
  output logic              ev_hold,
  output logic              busy
);
  seq_state_e         state_q;
  seq_phase_e         phase_q;
  logic [WORD_W-1:0]  addr_q;
  logic [WORD_W-1:0]  link_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [HOST_AW-1:0] off_q;

  always_comb begin
    mem_req_valid = (state_q == ST_REQ);
    mem_req_addr  = addr_q;
    mem_rsp_ready = (state_q == ST_RSP);
    busy          = (state_q != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      phase_q      <= PH_HDR;
      addr_q       <= '0;
      link_q       <= '0;
      cnt_q        <= '0;
      off_q        <= '0;
      wr_o         <= '0;
      ev_list_end  <= 1'b0;
      ev_chain_end <= 1'b0;
      ev_hold      <= 1'b0;
    end else begin
      wr_o.valid   <= 1'b0;
      ev_list_end  <= 1'b0;
      ev_chain_end <= 1'b0;
      ev_hold      <= 1'b0;
      if (cmd_halt) begin
        state_q <= ST_IDLE;
      end else if (cmd_start) begin
        state_q <= ST_REQ;
        phase_q <= PH_HDR;
        addr_q  <= base_addr;
      end else begin
        case (state_q)
          ST_REQ: if (mem_req_ready) state_q <= ST_RSP;
          ST_RSP: if (mem_rsp_valid) begin
            state_q <= ST_REQ;
            addr_q  <= addr_q + WORD_W'(4);
            case (phase_q)
              PH_HDR: begin
                cnt_q   <= mem_rsp_data[CNT_W-1:0];
                phase_q <= (mem_rsp_data[CNT_W-1:0] == '0) ? PH_LNK : PH_OFF;
              end
              PH_OFF: begin
                off_q   <= mem_rsp_data[HOST_AW-1:0];
                phase_q <= PH_VAL;
              end
              PH_VAL: begin
                wr_o.valid <= 1'b1;
                wr_o.off   <= off_q;
                wr_o.data  <= mem_rsp_data;
                cnt_q      <= cnt_q - CNT_W'(1);
                phase_q    <= (cnt_q == CNT_W'(1)) ? PH_LNK : PH_OFF;
              end
              default: begin
                ev_list_end <= 1'b1;
                phase_q     <= PH_HDR;
                if (mem_rsp_data == '0) begin
                  ev_chain_end <= 1'b1;
                  state_q      <= ST_IDLE;
                end else if (hold_list) begin
                  ev_hold <= 1'b1;
                  link_q  <= mem_rsp_data;
                  state_q <= ST_HOLD;
                end else begin
                  addr_q <= mem_rsp_data;
                end
              end
            endcase
          end
          ST_HOLD: if (cmd_cont) begin
            state_q <= ST_REQ;
            addr_q  <= link_q;
          end
          default: ;
        endcase
      end
    end
  end

  // R2: an offered request keeps its address until accepted
  a_r2_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !cmd_halt && !cmd_start)
      |=> (mem_req_valid && $stable(mem_req_addr)));

  // R4: no fetch while paused at a hold without a continue
  a_r4_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !cmd_cont && !cmd_start) |=> !mem_req_valid);

  // R5: chain end and hold never fire together
  a_r5_chain_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chain_end |-> !ev_hold);

  // R7: halt returns to idle
  a_r7_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_halt |=> !busy);
endmodule

// File: rtl/cls_cfgfile.sv
module cls_cfgfile
  import cls_pkg::*;
#(
  parameter int WORDS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  reg_wr_t            wr_i,
  input  logic               clr_i,
  input  logic [HOST_AW-1:0] rd_off,
  output logic [WORD_W-1:0]  rd_data
);
  logic [WORD_W-1:0] word_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    localparam logic [HOST_AW-1:0] MY_OFF = OFF_CFG0 + HOST_AW'(4 * i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               word_q[i] <= '0;
      else if (clr_i)                           word_q[i] <= '0;
      else if (wr_i.valid && wr_i.off == MY_OFF) word_q[i] <= wr_i.data;
    end
    // R11: soft reset wipes each window word
    a_r11_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (word_q[i] == '0));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < WORDS; i++)
      if (rd_off == OFF_CFG0 + HOST_AW'(4 * i)) rd_data = word_q[i];
  end
endmodule

// File: rtl/cls_blit_stub.sv
module cls_blit_stub #(
  parameter int LAT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt_q;
  logic          busy;

  assign busy = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (busy) begin
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) done_o <= 1'b1;
      end else if (start_i) begin
        cnt_q <= CW'(LAT);
      end
    end
  end

  // R8: an accepted start makes the stub busy
  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy) |=> busy);
endmodule

// File: rtl/cls_regs.sv
module cls_regs
  import cls_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [WORD_W-1:0]  host_wdata,
  output logic [WORD_W-1:0]  host_rdata,
  input  logic [WORD_W-1:0]  cfg_rdata,
  input  reg_wr_t            wr_i,
  input  logic               ev_list_end,
  input  logic               ev_chain_end,
  input  logic               ev_hold,
  input  logic               blit_done,
  output logic               cmd_start,
  output logic               cmd_cont,
  output logic               cmd_halt,
  output logic [WORD_W-1:0]  base_addr,
  output logic               hold_list,
  output logic               irq
);
  logic [3:0]        ien_q, pend_q, pend_set, pend_clr;
  logic [WORD_W-1:0] hold_q;
  logic [15:0]       blit_cnt_q;
  logic [7:0]        list_cnt_q;
  logic              done_q, cnt_clear;

  assign hold_list = hold_q[1];
  assign irq       = |(pend_q & ien_q);
  assign cnt_clear = cmd_start | cmd_halt;

  always_comb begin
    pend_set = '0;
    pend_set[PEND_BLIT]  = blit_done;
    pend_set[PEND_HOLD]  = ev_hold;
    pend_set[PEND_LEND]  = ev_list_end;
    pend_set[PEND_CHAIN] = ev_chain_end;
    pend_clr = (host_wr && host_addr == OFF_IPEND) ? host_wdata[3:0] : 4'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0; pend_q <= '0; hold_q <= '0; base_addr <= '0;
      cmd_start <= 1'b0; cmd_cont <= 1'b0; cmd_halt <= 1'b0;
      blit_cnt_q <= '0; list_cnt_q <= '0; done_q <= 1'b0;
    end else begin
      cmd_start <= 1'b0; cmd_cont <= 1'b0; cmd_halt <= 1'b0;
      if (host_wr) begin
        case (host_addr)
          OFF_IEN:  ien_q     <= host_wdata[3:0];
          OFF_BASE: base_addr <= host_wdata;
          OFF_HOLD: hold_q    <= host_wdata;
          OFF_CMD: begin
            cmd_halt  <= host_wdata[2];
            cmd_start <= host_wdata[0] & ~host_wdata[2];
            cmd_cont  <= host_wdata[1] & ~host_wdata[0] & ~host_wdata[2];
          end
          default: ;
        endcase
      end
      if (wr_i.valid && wr_i.off == OFF_HOLD) hold_q <= wr_i.data;
      pend_q <= (pend_q & ~pend_clr) | pend_set;
      if (cnt_clear) begin
        blit_cnt_q <= '0; list_cnt_q <= '0; done_q <= 1'b0;
      end else begin
        if (blit_done)    blit_cnt_q <= blit_cnt_q + 16'd1;
        if (ev_list_end)  list_cnt_q <= list_cnt_q + 8'd1;
        if (ev_chain_end) done_q     <= 1'b1;
      end
    end
  end

  always_comb begin
    case (host_addr)
      OFF_IEN:   host_rdata = {28'd0, ien_q};
      OFF_IPEND: host_rdata = {28'd0, pend_q};
      OFF_BASE:  host_rdata = base_addr;
      OFF_STAT:  host_rdata = {7'd0, list_cnt_q, blit_cnt_q, done_q};
      OFF_HOLD:  host_rdata = hold_q;
      default:   host_rdata = cfg_rdata;
    endcase
  end

  // R3: chain end sets pending bit 3 and done
  a_r3_chain_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_chain_end && !cnt_clear) |=> (pend_q[PEND_CHAIN] && done_q));

  // R10: write-one clears a pending bit with no new event
  a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr[PEND_CHAIN] && !ev_chain_end) |=> !pend_q[PEND_CHAIN]);

  // R7: start or halt clears counters and done
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> (blit_cnt_q == '0 && list_cnt_q == '0 && !done_q));
endmodule

// File: rtl/cmdlist_sequencer.sv
module cmdlist_sequencer
  import cls_pkg::*;
#(
  parameter int CFG_WORDS = 16,
  parameter int BLIT_LAT  = 8,
  parameter int CNT_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [11:0] host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        irq,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  output logic        mem_rsp_ready,
  input  logic [31:0] mem_rsp_data
);
  reg_wr_t           lwr;
  logic              cmd_start, cmd_cont, cmd_halt, hold_list;
  logic              ev_list_end, ev_chain_end, ev_hold, busy;
  logic              blit_start, blit_done, cfg_clr;
  logic [WORD_W-1:0] base_addr, cfg_rdata;

  assign blit_start = lwr.valid && lwr.off == OFF_BLIT   && lwr.data[0];
  assign cfg_clr    = lwr.valid && lwr.off == OFF_SRESET && lwr.data[1];

  cls_fetch #(.CNT_W(CNT_W)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .cmd_start(cmd_start), .cmd_cont(cmd_cont), .cmd_halt(cmd_halt),
    .base_addr(base_addr), .hold_list(hold_list),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .wr_o(lwr), .ev_list_end(ev_list_end), .ev_chain_end(ev_chain_end),
    .ev_hold(ev_hold), .busy(busy)
  );

  cls_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .cfg_rdata(cfg_rdata), .wr_i(lwr),
    .ev_list_end(ev_list_end), .ev_chain_end(ev_chain_end), .ev_hold(ev_hold),
    .blit_done(blit_done), .cmd_start(cmd_start), .cmd_cont(cmd_cont),
    .cmd_halt(cmd_halt), .base_addr(base_addr), .hold_list(hold_list), .irq(irq)
  );

  cls_cfgfile #(.WORDS(CFG_WORDS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(lwr), .clr_i(cfg_clr),
    .rd_off(host_addr), .rd_data(cfg_rdata)
  );

  cls_blit_stub #(.LAT(BLIT_LAT)) u_blit (
    .clk(clk), .rst_n(rst_n), .start_i(blit_start), .done_o(blit_done)
  );

  // R6: a continue while not busy leaves the bus idle
  a_r6_cont_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cont && !busy) |=> !mem_req_valid);
endmodule

// File: tb/tb_cmdlist_sequencer.sv
module tb_cmdlist_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        irq;
  logic        mem_req_valid, mem_rsp_ready;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  cmdlist_sequencer dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  logic [31:0] mem [0:511];
  logic [31:0] exp_q [$];
  int total = 0, bad = 0, nreq = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  initial begin
    int cyc = 0, delay = -1;
    logic [31:0] cur;
    for (int i = 0; i < 512; i++) mem[i] = '0;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (delay > 0) begin
        delay--;
        if (delay == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem[cur[10:2]];
          delay = -1;
        end
      end
      mem_req_ready = (cyc % 3) != 1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        cur = mem_req_addr; delay = 2; nreq++;
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R2 unexpected fetch actual=%h expected=none", cur);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          if (e !== cur) begin
            bad++;
            $display("FAIL R2 fetch address actual=%h expected=%h", cur, e);
          end
        end
      end
      cyc++;
    end
  end

  task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  // driver: lays a list into memory and queues its expected fetches
  task automatic put_list(input logic [31:0] a, input int n,
                          input logic [31:0] o0, v0, o1, v1,
                          input logic [31:0] lnk, input bit fetched);
    logic [31:0] w [6];
    w[0] = o0; w[1] = v0; w[2] = o1; w[3] = v1;
    mem[a[10:2]] = n;
    for (int i = 0; i < 2 * n; i++) mem[a[10:2] + 1 + i] = w[i];
    mem[a[10:2] + 1 + 2 * n] = lnk;
    if (fetched)
      for (int i = 0; i < 2 * n + 2; i++) exp_q.push_back(a + 4 * i);
  endtask

  task automatic wait_pend(input int bitn, input string tag);
    logic [31:0] p;
    for (int i = 0; i < 3000; i++) begin
      hread(12'h00C, p);
      if (p[bitn]) return;
    end
    chk({tag, " timeout"}, 32'd0, 32'd1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // reset state
    hread(12'h08C, r); chk("R3 reset status", r, 32'd0);
    hread(12'h00C, r); chk("R10 reset pending", r, 32'd0);
    chk("R10 reset irq", {31'd0, irq}, 32'd0);
    chk("R2 reset no request", {31'd0, mem_req_valid}, 32'd0);

    // two linked lists
    put_list(32'h100, 2, 32'h104, 32'hA5, 32'h110, 32'h1234, 32'h200, 1);
    put_list(32'h200, 1, 32'h140, 32'hBEEF, 0, 0, 32'h0, 1);
    hwrite(12'h004, 32'hF);
    hwrite(12'h080, 32'h100);
    hwrite(12'h084, 32'h1);
    wait_pend(3, "R3 chain end");
    idle(2);
    hread(12'h104, r); chk("R1 cfg word 0", r, 32'hA5);
    hread(12'h110, r); chk("R1 cfg word 3", r, 32'h1234);
    hread(12'h140, r); chk("R1 cfg word 15", r, 32'hBEEF);
    hread(12'h08C, r); chk("R3 status after chain", r, (32'd2 << 17) | 32'd1);
    hread(12'h00C, r); chk("R9 pending list end and chain", r, 32'hC);
    chk("R10 irq enabled", {31'd0, irq}, 32'd1);
    hwrite(12'h004, 32'h0); idle(1);
    chk("R10 irq masked", {31'd0, irq}, 32'd0);
    hwrite(12'h004, 32'hF);
    hwrite(12'h00C, 32'h8);
    hread(12'h00C, r); chk("R10 w1c bit3 only", r, 32'h4);
    hwrite(12'h00C, 32'hF); idle(1);
    chk("R10 irq after clear", {31'd0, irq}, 32'd0);
    chk("R2 scoreboard drained", exp_q.size(), 32'd0);

    // hold between lists, blit from a list
    put_list(32'h300, 2, 32'h090, 32'h2, 32'h100, 32'h1, 32'h380, 1);
    hwrite(12'h080, 32'h300);
    hwrite(12'h084, 32'h1);
    wait_pend(1, "R4 hold");
    hread(12'h08C, r);
    chk("R4 list count at hold", r[24:17], 32'd1);
    chk("R4 not done at hold", r[0], 32'd0);
    chk("R4 irq at hold", {31'd0, irq}, 32'd1);
    n0 = nreq;
    idle(20);
    chk("R4 no fetch while held", nreq, n0);
    wait_pend(0, "R8 blit done");
    idle(2);
    hread(12'h08C, r); chk("R8 blit count", r[16:1], 32'd1);
    put_list(32'h380, 2, 32'h090, 32'h0, 32'h108, 32'h7, 32'h0, 1);
    hwrite(12'h084, 32'h2);
    wait_pend(3, "R4 resumed chain");
    idle(2);
    hread(12'h108, r); chk("R4 second list applied", r, 32'h7);
    hread(12'h08C, r); chk("R4 status after resume", r, (32'd2 << 17) | (32'd1 << 1) | 32'd1);
    hread(12'h090, r); chk("R12 list cleared hold", r, 32'd0);

    // continue while idle
    n0 = nreq;
    hwrite(12'h084, 32'h2);
    idle(20);
    chk("R6 continue while idle fetches nothing", nreq, n0);
    hread(12'h08C, r); chk("R6 status unchanged", r, (32'd2 << 17) | (32'd1 << 1) | 32'd1);

    // hold armed on the last list
    hwrite(12'h00C, 32'hF);
    put_list(32'h400, 1, 32'h090, 32'h2, 0, 0, 32'h0, 1);
    hwrite(12'h080, 32'h400);
    hwrite(12'h084, 32'h1);
    wait_pend(3, "R5 chain end");
    idle(2);
    hread(12'h00C, r); chk("R5 no hold pending", r[1], 32'd0);
    hread(12'h08C, r); chk("R7 start cleared counts", r, (32'd1 << 17) | 32'd1);
    hread(12'h090, r); chk("R5 hold still armed", r, 32'h2);
    hwrite(12'h090, 32'h0);
    hread(12'h090, r); chk("R12 host cleared hold", r, 32'd0);

    // soft reset from a list
    hwrite(12'h00C, 32'hF);
    hwrite(12'h104, 32'h0);
    put_list(32'h480, 1, 32'h000, 32'h2, 0, 0, 32'h0, 1);
    hwrite(12'h080, 32'h480);
    hwrite(12'h084, 32'h1);
    wait_pend(3, "R11 chain end");
    idle(2);
    hread(12'h104, r); chk("R11 cfg 0 cleared", r, 32'd0);
    hread(12'h110, r); chk("R11 cfg 3 cleared", r, 32'd0);
    hread(12'h140, r); chk("R11 cfg 15 cleared", r, 32'd0);
    hread(12'h108, r); chk("R11 cfg 1 cleared", r, 32'd0);

    // halt at a hold
    hwrite(12'h00C, 32'hF);
    hwrite(12'h090, 32'h2);
    put_list(32'h500, 1, 32'h10C, 32'h9, 0, 0, 32'h580, 1);
    put_list(32'h580, 1, 32'h10C, 32'h55, 0, 0, 32'h0, 0);
    hwrite(12'h080, 32'h500);
    hwrite(12'h084, 32'h1);
    wait_pend(1, "R7 hold before halt");
    idle(2);
    hread(12'h10C, r); chk("R1 cfg 2 written", r, 32'h9);
    hwrite(12'h084, 32'h4);
    idle(3);
    hread(12'h08C, r); chk("R7 halt cleared status", r, 32'd0);
    n0 = nreq;
    hwrite(12'h084, 32'h2);
    idle(20);
    chk("R6 continue after halt ignored", nreq, n0);
    hread(12'h10C, r); chk("R7 halted list not applied", r, 32'h9);
    chk("R2 scoreboard empty at end", exp_q.size(), 32'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule